// File: doc/BRIEF.md
# Programmable interval timer channel

This block is one counter channel of a byte-programmed interval timer. Software talks to it through two byte-wide ports. A command byte picks how the data port is sequenced, which waveform the channel produces, and whether the current count should be frozen for reading. A data byte either loads part of the 16-bit reload value or returns part of the count.

The counter decrements once per cycle in which the clock-enable input is high. A rate-generator waveform gives a one-enable low pulse per period. A square-wave waveform splits each period into a high half and a low half. All other mode codes keep the counter running but hold the output high.

Because both loading and reading pass through an 8-bit port, the block keeps separate low/high byte toggles for writes and for reads. It also keeps a snapshot register, so a count read in two halves comes from one instant.

Top module: `pit_channel`

## Requirements
- R1: After synchronous reset the output is high, the count is 0x0000 and the port is in two-byte access. In that state two data reads return 0x00 and then 0x00.
- R2: In two-byte access (command bits 5:4 = 11), the first data write supplies the low byte of the reload value and the second supplies the high byte. Data reads return the low byte first, then the high byte.
- R3: A command whose bits 5:4 are nonzero stops the counter, and the count keeps its value. A newly written reload value reaches the count on the first enabled cycle after its last byte. Before that cycle a read still shows the previous count.
- R4: For mode codes other than 2, 3, 6 and 7 (command bits 3:1), the count drops by one per enable and returns to the reload value after reaching zero.
- R5: A latch command (bits 5:4 = 00) copies the count into a snapshot. Reads then return the snapshot however far the counter runs on. Once the snapshot has been fully read, reads show the live count again.
- R6: A latch command is ignored while a snapshot is still unread. The snapshot is released after its last byte is read: the high byte in two-byte access, the single byte otherwise.
- R7: With bits 5:4 = 01, one data write loads the reload value as 0x00 high and the written byte low, and every read returns the low byte. With bits 5:4 = 10, the written byte becomes the high byte over a zero low byte, and every read returns the high byte.
- R8: A command with nonzero bits 5:4 resets both the write and the read byte toggles to the low byte.
- R9: With mode code 2, the output is low for exactly the one enable in which the count equals 1. The next enable loads the reload value N, so the low pulse repeats every N enables.
- R10: With mode code 3, the count steps down by two from the reload value rounded down to even. The output starts high when the count is loaded and inverts each time the count reloads from 2. For an even N this gives N/2 enables per half.
- R11: Mode codes 6 and 7 behave exactly as mode codes 2 and 3.
- R12: Command bit 0 (decimal counting request) is ignored. Counting is always binary, so reload 0x0010 followed by one further enable reads 0x000F.
- R13: A command whose bits 7:6 do not equal CHAN_SEL, including the value 11, has no effect on mode, access, counting or output.
- R14: After a mode command the output is high and stays high, even with enables, until a new reload value has been written and loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the command byte |
| data_we | input | 1 | Write strobe for the data byte |
| data_rd | input | 1 | Read strobe; advances the read byte toggle and may release the snapshot |
| wr_data | input | 8 | Byte written to the command or data port |
| cnt_en | input | 1 | Counting clock enable |
| rd_data | output | 8 | Byte presented by the data port in the current cycle |
| out_pin | output | 1 | Waveform output |

## Verification
The bench builds the channel with CHAN_SEL at its default of 0. This makes command bytes 0x40 to 0xBF foreign and lets the bench show that they, and the 0xC0 to 0xFF read-back space, are rejected without disturbing a running waveform. Small reload values (3 to 6) bring the reload-from-1, reload-from-2 and reload-from-zero transitions within a few enables, so whole periods of both waveforms can be compared edge by edge. Long runs between a latch and its reads show that the snapshot holds and that a second latch is refused.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    // Data-port sequencing chosen by command bits 5:4
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    // Output behaviour derived from the mode code
    typedef enum logic [1:0] {
        WAVE_FLAT   = 2'b00,
        WAVE_RATE   = 2'b01,
        WAVE_SQUARE = 2'b10
    } wave_e;

    // Command byte: select, access, then mode code and format bit
    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [3:0] fmt;
    } cmd_t;

    // fmt = {mode[2:0], decimal_request}; the format bit and mode[2] do not matter
    function automatic wave_e wave_of(input logic [3:0] fmt);
        wave_e w;
        casez (fmt)
            4'b?10?: w = WAVE_RATE;
            4'b?11?: w = WAVE_SQUARE;
            default: w = WAVE_FLAT;
        endcase
        return w;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                    input logic hi);
        return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
#(
    parameter int CHAN_SEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wr_data,
    output acc_e              acc,
    output wave_e             wave,
    output logic [CNT_W-1:0]  reload,
    output logic              load_req,
    output logic              mode_wr,
    output logic              latch_req
);

    localparam logic [1:0] OWN_SEL = CHAN_SEL[1:0];

    cmd_t              cmd;
    logic              hit;
    acc_e              acc_q;
    wave_e             wave_q;
    logic              wr_hi_q;
    logic [BYTE_W-1:0] lo_q;
    logic [CNT_W-1:0]  reload_q;

    assign cmd       = cmd_t'(wr_data);
    assign hit       = cmd_we && (cmd.sel == OWN_SEL);
    assign mode_wr   = hit && (cmd.acc != ACC_LATCH);
    assign latch_req = hit && (cmd.acc == ACC_LATCH);
    assign load_req  = data_we && !mode_wr && ((acc_q != ACC_WORD) || wr_hi_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= ACC_WORD;
            wave_q   <= WAVE_FLAT;
            wr_hi_q  <= 1'b0;
            lo_q     <= '0;
            reload_q <= '0;
        end else if (mode_wr) begin
            acc_q   <= cmd.acc;
            wave_q  <= wave_of(cmd.fmt);
            wr_hi_q <= 1'b0;
        end else if (data_we) begin
            unique case (acc_q)
                ACC_LO: reload_q <= {{BYTE_W{1'b0}}, wr_data};
                ACC_HI: reload_q <= {wr_data, {BYTE_W{1'b0}}};
                default: begin
                    if (wr_hi_q) begin
                        reload_q <= {wr_data, lo_q};
                        wr_hi_q  <= 1'b0;
                    end else begin
                        lo_q    <= wr_data;
                        wr_hi_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign acc    = acc_q;
    assign wave   = wave_q;
    assign reload = reload_q;

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             mode_wr,
    input  logic             load_req,
    input  wave_e            wave,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             out_pin
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] nxt_count;
    logic [CNT_W-1:0] even_reload;
    logic [CNT_W-1:0] start_val;
    logic             run_q;
    logic             pend_q;
    logic             sq_q;
    logic             nxt_sq;

    assign even_reload = {reload[CNT_W-1:1], 1'b0};
    assign start_val   = (wave == WAVE_SQUARE) ? even_reload : reload;

    always_comb begin
        nxt_count = count_q;
        nxt_sq    = sq_q;
        if (pend_q) begin
            nxt_count = start_val;
            nxt_sq    = 1'b1;
        end else if (run_q) begin
            unique case (wave)
                WAVE_RATE:
                    nxt_count = (count_q == CNT_W'(1)) ? reload : count_q - CNT_W'(1);
                WAVE_SQUARE: begin
                    if (count_q == CNT_W'(2)) begin
                        nxt_count = even_reload;
                        nxt_sq    = ~sq_q;
                    end else begin
                        nxt_count = count_q - CNT_W'(2);
                    end
                end
                default:
                    nxt_count = (count_q == '0) ? reload : count_q - CNT_W'(1);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
            pend_q  <= 1'b0;
            sq_q    <= 1'b1;
        end else if (mode_wr) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
            sq_q   <= 1'b1;
        end else if (cnt_en) begin
            count_q <= nxt_count;
            sq_q    <= nxt_sq;
            if (pend_q) run_q <= 1'b1;
            pend_q  <= load_req;
        end else if (load_req) begin
            pend_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (wave)
            WAVE_RATE:   out_pin = !(run_q && (count_q == CNT_W'(1)));
            WAVE_SQUARE: out_pin = !run_q || sq_q;
            default:     out_pin = 1'b1;
        endcase
    end

    assign count = count_q;

endmodule

// File: rtl/pit_readout.sv
module pit_readout
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [CNT_W-1:0]  count,
    input  logic              latch_req,
    input  logic              mode_wr,
    input  logic              data_rd,
    output logic [BYTE_W-1:0] rd_data
);

    logic             held_q;
    logic             rd_hi_q;
    logic [CNT_W-1:0] snap_q;
    logic [CNT_W-1:0] src;
    logic             take_hi;
    logic             last_byte;

    assign src       = held_q ? snap_q : count;
    assign last_byte = (acc != ACC_WORD) || rd_hi_q;

    always_comb begin
        unique case (acc)
            ACC_LO:  take_hi = 1'b0;
            ACC_HI:  take_hi = 1'b1;
            default: take_hi = rd_hi_q;
        endcase
    end

    assign rd_data = pick_byte(src, take_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= 1'b0;
            rd_hi_q <= 1'b0;
            snap_q  <= '0;
        end else if (mode_wr) begin
            held_q  <= 1'b0;
            rd_hi_q <= 1'b0;
        end else begin
            if (data_rd) begin
                if (acc == ACC_WORD) rd_hi_q <= ~rd_hi_q;
                if (held_q && last_byte) held_q <= 1'b0;
            end
            if (latch_req && !held_q) begin
                held_q <= 1'b1;
                snap_q <= count;
            end
        end
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CHAN_SEL = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              data_we,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cnt_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              out_pin
);

    acc_e             acc;
    wave_e            wave;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             load_req;
    logic             mode_wr;
    logic             latch_req;

    pit_ctrl #(.CHAN_SEL(CHAN_SEL)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (cmd_we),
        .data_we   (data_we),
        .wr_data   (wr_data),
        .acc       (acc),
        .wave      (wave),
        .reload    (reload),
        .load_req  (load_req),
        .mode_wr   (mode_wr),
        .latch_req (latch_req)
    );

    pit_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .mode_wr  (mode_wr),
        .load_req (load_req),
        .wave     (wave),
        .reload   (reload),
        .count    (count),
        .out_pin  (out_pin)
    );

    pit_readout u_read (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .count     (count),
        .latch_req (latch_req),
        .mode_wr   (mode_wr),
        .data_rd   (data_rd),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
    import pit_pkg::*;
#(
    parameter int CHAN_SEL = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_we,
    input logic              data_rd,
    input logic              cnt_en,
    input logic [BYTE_W-1:0] wr_data,
    input logic              out_pin,
    input wave_e             wave,
    input acc_e              acc,
    input logic [CNT_W-1:0]  reload,
    input logic              held,
    input logic [CNT_W-1:0]  snap,
    input logic              pend
);

    localparam logic [1:0] OWN_SEL = CHAN_SEL[1:0];

    // R9 R10 R14
    out_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_pin) |-> ($past(cnt_en) || $past(cmd_we)));

    // R14
    halt_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && wr_data[7:6] == OWN_SEL && wr_data[5:4] != 2'b00) |=> out_pin);

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        held |=> $stable(snap));

    // R13
    foreign_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && wr_data[7:6] != OWN_SEL && !data_rd)
        |=> ($stable(wave) && $stable(acc) && $stable(held)));

    // R9
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        (wave == WAVE_RATE && !out_pin && cnt_en && !cmd_we && !pend
         && reload != CNT_W'(1)) |=> out_pin);

endmodule

bind pit_channel pit_channel_chk #(.CHAN_SEL(CHAN_SEL)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cmd_we  (cmd_we),
    .data_rd (data_rd),
    .cnt_en  (cnt_en),
    .wr_data (wr_data),
    .out_pin (out_pin),
    .wave    (wave),
    .acc     (acc),
    .reload  (reload),
    .held    (u_read.held_q),
    .snap    (u_read.snap_q),
    .pend    (u_cnt.pend_q)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 1'b0;
    logic       data_we = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cnt_en = 1'b0;
    logic [7:0] rd_data;
    logic       out_pin;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    pit_channel u_dut (
        .clk     (clk),
        .rst     (rst),
        .cmd_we  (cmd_we),
        .data_we (data_we),
        .data_rd (data_rd),
        .wr_data (wr_data),
        .cnt_en  (cnt_en),
        .rd_data (rd_data),
        .out_pin (out_pin)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic send_cmd(logic [7:0] b);
        @(negedge clk);
        cmd_we  = 1'b1;
        wr_data = b;
        @(negedge clk);
        cmd_we  = 1'b0;
    endtask

    task automatic send_data(logic [7:0] b);
        @(negedge clk);
        data_we = 1'b1;
        wr_data = b;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic rd_expect(logic [7:0] v, string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        @(negedge clk);
        sb_q.push_back(e);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic enables(int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    // k counts enabled edges since the loading edge (k = 0)
    task automatic run_wave(int k0, int n_edges, bit square, int per, string tag);
        @(negedge clk);
        cnt_en = 1'b1;
        for (int k = k0; k < k0 + n_edges; k++) begin
            logic exp_out;
            @(negedge clk);
            #1;
            if (square) exp_out = ((k / (per / 2)) % 2) == 0;
            else        exp_out = (k % per) != (per - 1);
            chk(tag, {15'd0, out_pin}, {15'd0, exp_out});
        end
        cnt_en = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever the bench reads the data port
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #2;
            if (data_rd) begin
                if (sb_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL scoreboard: read with no expected item, actual 0x%0h expected none", rd_data);
                end else begin
                    e = sb_q.pop_front();
                    chk(e.tag, {8'd0, rd_data}, {8'd0, e.val});
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        #1;
        chk("R1 out", {15'd0, out_pin}, 16'd1);
        rd_expect(8'h00, "R1 low");
        rd_expect(8'h00, "R1 high");

        // R3 write without enable leaves old count; R2 ordering after load
        send_cmd(8'h30);
        send_data(8'h34);
        send_data(8'h12);
        rd_expect(8'h00, "R3 before enable low");
        rd_expect(8'h00, "R3 before enable high");
        enables(1);
        rd_expect(8'h34, "R2 low");
        rd_expect(8'h12, "R2 high");

        // R4 count to zero then back to reload
        send_cmd(8'h30);
        send_data(8'h03);
        send_data(8'h00);
        enables(4);
        rd_expect(8'h00, "R4 zero low");
        rd_expect(8'h00, "R4 zero high");
        enables(1);
        rd_expect(8'h03, "R4 wrap low");
        rd_expect(8'h00, "R4 wrap high");

        // R5 latch freezes, released after both bytes
        send_cmd(8'h30);
        send_data(8'h00);
        send_data(8'h20);
        enables(1);
        send_cmd(8'h00);
        enables(5);
        rd_expect(8'h00, "R5 snapshot low");
        rd_expect(8'h20, "R5 snapshot high");
        rd_expect(8'hFB, "R5 live low");
        rd_expect(8'h1F, "R5 live high");

        // R6 second latch ignored while held
        send_cmd(8'h00);
        enables(2);
        send_cmd(8'h00);
        enables(1);
        rd_expect(8'hFB, "R6 first snapshot low");
        rd_expect(8'h1F, "R6 first snapshot high");
        send_cmd(8'h00);
        rd_expect(8'hF8, "R6 fresh snapshot low");
        rd_expect(8'h1F, "R6 fresh snapshot high");

        // R7 single-byte access modes
        send_cmd(8'h10);
        send_data(8'hAB);
        enables(1);
        rd_expect(8'hAB, "R7 low only");
        rd_expect(8'hAB, "R7 low only repeat");
        send_cmd(8'h20);
        send_data(8'h5C);
        enables(1);
        rd_expect(8'h5C, "R7 high only");
        rd_expect(8'h5C, "R7 high only repeat");

        // R8 command resets write and read toggles
        send_cmd(8'h30);
        send_data(8'h11);
        send_cmd(8'h30);
        send_data(8'h22);
        send_data(8'h33);
        enables(1);
        rd_expect(8'h22, "R8 low");
        send_cmd(8'h30);
        rd_expect(8'h22, "R8 low after command");
        rd_expect(8'h33, "R8 high after command");

        // R12 decimal request counts in binary
        send_cmd(8'h31);
        send_data(8'h10);
        send_data(8'h00);
        enables(2);
        rd_expect(8'h0F, "R12 low");
        rd_expect(8'h00, "R12 high");

        // R9 rate generator, period 4
        send_cmd(8'h34);
        send_data(8'h04);
        send_data(8'h00);
        run_wave(0, 13, 1'b0, 4, "R9 rate");

        // R13 foreign select and read-back commands ignored
        send_cmd(8'h74);
        send_cmd(8'hC4);
        run_wave(13, 8, 1'b0, 4, "R13 after foreign commands");

        // R14 mode command forces output high and halts
        run_wave(21, 3, 1'b0, 4, "R9 low before command");
        send_cmd(8'h34);
        #1;
        chk("R14 high after command", {15'd0, out_pin}, 16'd1);
        @(negedge clk);
        cnt_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1;
            chk("R14 halted", {15'd0, out_pin}, 16'd1);
        end
        cnt_en = 1'b0;

        // R10 square wave, reload 6
        send_cmd(8'h36);
        send_data(8'h06);
        send_data(8'h00);
        run_wave(0, 15, 1'b1, 6, "R10 square");

        // R11 mode codes 6 and 7
        send_cmd(8'h3C);
        send_data(8'h05);
        send_data(8'h00);
        run_wave(0, 11, 1'b0, 5, "R11 code 6 rate");
        send_cmd(8'h3E);
        send_data(8'h04);
        send_data(8'h00);
        run_wave(0, 9, 1'b1, 4, "R11 code 7 square");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d items left expected 0", sb_q.size());
        end
        summary();
        $finish;
    end

endmodule